// File: doc/BRIEF.md
# Shared-Multiplier Arithmetic Unit

This block is an 8-bit arithmetic unit. It multiplies, adds, subtracts and multiply-accumulates on a single datapath. The datapath has four 4x4 nibble multipliers followed by a partial-product combiner. There is no separate adder for the add and subtract modes. Each operand nibble is passed through one of the four nibble multipliers with its second input tied to one. The combiner then adds the low nibbles, carries into the high nibbles, and applies a forced carry-in of one when subtracting.

A 4-bit select chooses the operation. A start strobe launches it. The 16-bit result and a one-cycle done pulse are registered on the next clock edge. A 16-bit accumulator sits behind the multiply-accumulate mode, and a synchronous clear input sets it to zero. Select codes that name no operation return zero and leave the accumulator untouched.

Top module: `mul_shared_au`

## Requirements
- R1: With select 4'b0001 and start high, the result on the next edge is the exact 16-bit unsigned product of the two operands.
- R2: With select 4'b0100 and start high, the result is the 9-bit sum of the operands zero-extended to 16 bits. Bit 8 is the carry out.
- R3: With select 4'b0110 and start high, bits 7..0 of the result hold (A-B) mod 256 and bit 8 is high exactly when A >= B (not-borrow). Bits 15..9 are zero.
- R4: With select 4'b1001 and start high, the accumulator becomes (accumulator + A*B) mod 2^16 and the result shows that new accumulator value.
- R5: The clear input sets the accumulator to zero on the next edge. Clear wins over an accumulate started in the same cycle.
- R6: A start with any select code other than the four above gives a zero result and leaves the accumulator unchanged.
- R7: Done is high for exactly the one cycle that follows each cycle in which start is high, and is low otherwise.
- R8: While start is low, the result keeps its last value whatever the operands and select do.
- R9: Active-low reset sets the result, the done flag and the accumulator to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous accumulator clear |
| start | input | 1 | Launch strobe for one operation |
| sel | input | 4 | Operation select code |
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| result | output | 16 | Registered result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The accumulator can only be seen through the result of a later accumulate, and that makes it the hardest state to reach from the ports. The bench therefore chains accumulates until the sum wraps past 2^16. It places an undefined select code, and separately a clear issued together with a start, between two accumulates. Each later result then shows whether the hidden register moved. Subtraction corners (equal operands, zero minus all-ones) exercise the forced carry-in and the not-borrow bit.

// File: rtl/au_pkg.sv
package au_pkg;

  localparam logic [3:0] SEL_MUL = 4'b0001;
  localparam logic [3:0] SEL_ADD = 4'b0100;
  localparam logic [3:0] SEL_SUB = 4'b0110;
  localparam logic [3:0] SEL_MAC = 4'b1001;

  typedef enum logic [2:0] {
    MD_NONE,
    MD_MUL,
    MD_ADD,
    MD_SUB,
    MD_MAC
  } au_mode_e;

  function automatic au_mode_e decode_sel(input logic [3:0] s);
    case (s)
      SEL_MUL: return MD_MUL;
      SEL_ADD: return MD_ADD;
      SEL_SUB: return MD_SUB;
      SEL_MAC: return MD_MAC;
      default: return MD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/au_operand_mux.sv
module au_operand_mux
  import au_pkg::*;
#(
  parameter int W = 8
) (
  input  au_mode_e                  mode,
  input  logic [W-1:0]              a,
  input  logic [W-1:0]              b,
  output logic [3:0][W/2-1:0]       x,
  output logic [3:0][W/2-1:0]       y,
  output logic                      cin
);
  localparam int H = W / 2;
  localparam logic [H-1:0] ONE = H'(1);

  logic [H-1:0] al, ah, bl, bh;
  assign al = a[H-1:0];
  assign ah = a[W-1:H];
  assign bl = b[H-1:0];
  assign bh = b[W-1:H];

  always_comb begin
    x   = '0;
    y   = '0;
    cin = 1'b0;
    case (mode)
      MD_MUL, MD_MAC: begin
        x = {ah, ah, al, al};
        y = {bh, bl, bh, bl};
      end
      MD_ADD: begin
        x = {ah, bh, bl, al};
        y = {ONE, ONE, ONE, ONE};
      end
      MD_SUB: begin
        x   = {ah, ~bh, ~bl, al};
        y   = {ONE, ONE, ONE, ONE};
        cin = 1'b1;
      end
      default: begin
        x = '0;
        y = '0;
      end
    endcase
  end
endmodule

// File: rtl/au_nib_mul.sv
module au_nib_mul #(
  parameter int H = 4
) (
  input  logic [H-1:0]   x,
  input  logic [H-1:0]   y,
  output logic [2*H-1:0] p
);
  assign p = (2*H)'(x) * (2*H)'(y);
endmodule

// File: rtl/au_pp_combine.sv
module au_pp_combine
  import au_pkg::*;
#(
  parameter int W = 8
) (
  input  au_mode_e                 mode,
  input  logic [3:0][W-1:0]        p,
  input  logic                     cin,
  output logic [2*W-1:0]           val
);
  localparam int H  = W / 2;
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] join_product(input logic [3:0][W-1:0] pp);
    logic [PW-1:0] mid;
    mid = PW'(pp[1]) + PW'(pp[2]);
    return (PW'(pp[3]) << W) + (mid << H) + PW'(pp[0]);
  endfunction

  function automatic logic [PW-1:0] join_sum(input logic [3:0][W-1:0] pp,
                                             input logic c);
    logic [H:0] lo, hi;
    lo = {1'b0, pp[0][H-1:0]} + {1'b0, pp[1][H-1:0]} + (H+1)'(c);
    hi = {1'b0, pp[3][H-1:0]} + {1'b0, pp[2][H-1:0]} + (H+1)'(lo[H]);
    return PW'({hi, lo[H-1:0]});
  endfunction

  always_comb begin
    case (mode)
      MD_MUL, MD_MAC: val = join_product(p);
      MD_ADD, MD_SUB: val = join_sum(p, cin);
      default:        val = '0;
    endcase
  end
endmodule

// File: rtl/au_acc.sv
module au_acc #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [PW-1:0] nxt,
  output logic [PW-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (clr)   acc <= '0;
    else if (load)  acc <= nxt;
  end
endmodule

// File: rtl/mul_shared_au.sv
module mul_shared_au
  import au_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [3:0]       sel,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  output logic [2*W-1:0]   result,
  output logic             done
);
  localparam int H  = W / 2;
  localparam int PW = 2 * W;

  au_mode_e            mode;
  logic [3:0][H-1:0]   mx, my;
  logic [3:0][W-1:0]   pp;
  logic                cin;
  logic [PW-1:0]       dp_val;
  logic [PW-1:0]       acc_q;
  logic [PW-1:0]       acc_sum;
  logic                acc_load;

  assign mode = decode_sel(sel);

  au_operand_mux #(.W(W)) u_mux (
    .mode(mode), .a(opa), .b(opb), .x(mx), .y(my), .cin(cin)
  );

  for (genvar g = 0; g < 4; g++) begin : g_lane
    au_nib_mul #(.H(H)) u_mul (.x(mx[g]), .y(my[g]), .p(pp[g]));
  end

  au_pp_combine #(.W(W)) u_comb (
    .mode(mode), .p(pp), .cin(cin), .val(dp_val)
  );

  assign acc_sum  = acc_q + dp_val;
  assign acc_load = start && (mode == MD_MAC);

  au_acc #(.PW(PW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(acc_load),
    .nxt(acc_sum), .acc(acc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= start;
      if (start) result <= (mode == MD_MAC) ? acc_sum : dp_val;
    end
  end
endmodule

// File: rtl/au_checker.sv
module au_checker
  import au_pkg::*;
#(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr,
  input logic           start,
  input logic [3:0]     sel,
  input logic [2*W-1:0] result,
  input logic           done,
  input logic [2*W-1:0] acc
);
  logic bad_code;
  assign bad_code = (decode_sel(sel) == MD_NONE);

  assert_done_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));
  assert_bad_code_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bad_code) |=> (result == '0));
  assert_bad_code_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bad_code && !clr) |=> $stable(acc));
  assert_clear_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));
  assert_add_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel == SEL_ADD) |=> (result[2*W-1:W+1] == '0));
endmodule

bind mul_shared_au au_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .sel(sel),
  .result(result), .done(done), .acc(acc_q)
);

// File: tb/mul_shared_au_tb.sv
module mul_shared_au_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  sel = 4'b0000;
  logic [7:0]  opa = 8'h00;
  logic [7:0]  opb = 8'h00;
  logic [15:0] result;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mul_shared_au u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .sel(sel),
    .opa(opa), .opb(opb), .result(result), .done(done)
  );

  // {sel, a, b, expected}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {4'b0001, 8'hFF, 8'hFF, 16'hFE01},  // R1
    {4'b0001, 8'h12, 8'h34, 16'h03A8},  // R1
    {4'b0001, 8'h80, 8'h02, 16'h0100},  // R1
    {4'b0100, 8'hFF, 8'hFF, 16'h01FE},  // R2
    {4'b0100, 8'h0F, 8'h01, 16'h0010},  // R2
    {4'b0100, 8'h35, 8'h4A, 16'h007F},  // R2
    {4'b0110, 8'h05, 8'h03, 16'h0102},  // R3
    {4'b0110, 8'h03, 8'h05, 16'h00FE},  // R3
    {4'b0110, 8'h80, 8'h80, 16'h0100},  // R3
    {4'b0110, 8'h00, 8'hFF, 16'h0001},  // R3
    {4'b1111, 8'hFF, 8'hFF, 16'h0000},  // R6
    {4'b0000, 8'hAB, 8'hCD, 16'h0000}   // R6
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] s, input logic [7:0] a, input logic [7:0] b,
                        input logic c);
    @(negedge clk);
    sel = s; opa = a; opb = b; start = 1'b1; clr = c;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 result", result, 16'h0000);
    check("R9 done", {15'd0, done}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][35:32], VEC[i][31:24], VEC[i][23:16], 1'b0);
      check($sformatf("R1/R2/R3/R6 vec%0d", i), result, VEC[i][15:0]);
      check("R7 done high", {15'd0, done}, 16'h0001);
    end
    @(negedge clk);
    check("R7 done low", {15'd0, done}, 16'h0000);

    // R9: accumulator starts at zero after reset
    run_op(4'b1001, 8'h03, 8'h05, 1'b0);
    check("R9 acc zero", result, 16'h000F);

    // R8: hold while idle
    run_op(4'b0001, 8'h12, 8'h34, 1'b0);
    sel = 4'b0100; opa = 8'hFF; opb = 8'h11;
    repeat (3) @(negedge clk);
    check("R8 hold", result, 16'h03A8);
    check("R7 idle done", {15'd0, done}, 16'h0000);

    // R4 accumulate chain with wrap
    pulse_clr();
    run_op(4'b1001, 8'h10, 8'h10, 1'b0);
    check("R4 mac1", result, 16'h0100);
    run_op(4'b1001, 8'hFF, 8'hFF, 1'b0);
    check("R4 mac2", result, 16'hFF01);
    run_op(4'b1001, 8'hFF, 8'hFF, 1'b0);
    check("R4 wrap", result, 16'hFD02);

    // R6: undefined code leaves accumulator alone
    run_op(4'b1010, 8'hFF, 8'hFF, 1'b0);
    check("R6 zero", result, 16'h0000);
    run_op(4'b1001, 8'h01, 8'h01, 1'b0);
    check("R6 acc kept", result, 16'hFD03);

    // R5: clear, and clear beating a same-cycle accumulate
    pulse_clr();
    run_op(4'b1001, 8'h01, 8'h02, 1'b0);
    check("R5 cleared", result, 16'h0002);
    run_op(4'b1001, 8'h01, 8'h01, 1'b1);
    run_op(4'b1001, 8'h01, 8'h01, 1'b0);
    check("R5 priority", result, 16'h0001);

    // R9: reset mid-run
    run_op(4'b1001, 8'h20, 8'h20, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 rerst result", result, 16'h0000);
    rst_n = 1'b1;
    run_op(4'b1001, 8'h01, 8'h01, 1'b0);
    check("R9 rerst acc", result, 16'h0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule